// File: doc/BRIEF.md
# Coarse/Fine Interval Readout Sequencer

This block is the synchronous digital controller of a two-step time-interval converter. An analog front end holds one voltage per coarse channel. Each channel covers one 8 ns slot, and fifteen slots give a 120 ns span. Two comparator banks report, for every channel, whether its held voltage is above a high threshold (channel full) and whether it is above a low threshold (channel touched). The sequencer follows the measurement phases from two asynchronous event inputs. When START arrives it enters a reset phase. A rising STOP moves it to the charge phase, and a falling STOP moves it to the hold phase.

In the hold phase the sequencer takes a snapshot of both comparator vectors. It counts the full channels to form a 4-bit coarse value. It then looks for the single partially charged channel, which is the channel whose index equals the coarse count. If that channel exists, the sequencer closes exactly one of fifteen switches to route it to a shared 5-bit ADC. It waits a settle time, starts the ADC, and takes the fine code when the ADC reports completion. The 9-bit result carries the coarse count in bits [8:5] and the fine code in bits [4:0]. It leaves the block on a valid/ready output with two qualifying flags. Back-pressure rule: once `res_valid` is high, `res_data` and both flags stay unchanged until a cycle in which `res_ready` is high. A following measurement that finishes during that time waits and is not dropped. A new START during readout cancels the measurement in progress.

Top module: `tdc_readout_seq`

## Requirements
- R1: A START rising edge (after two synchronizer flops) enters the reset phase from any state. In the reset phase a STOP rising edge enters charge, and in charge a STOP falling edge enters hold. A STOP pulse seen outside the reset phase produces no ADC start and no result.
- R2: The coarse field `res_data[8:5]` equals the number of set bits in the high vector `hi_cmp` snapshot. Bit i of `hi_cmp` means channel i is above the high threshold.
- R3: The partial channel is index c = coarse count, when `lo_cmp[c]`=1 and `hi_cmp[c]`=0. Bit i of `lo_cmp` means channel i is above the low threshold. Only then is `sw_sel` driven to the one-hot value with bit c set. `sw_sel` never has more than one bit set.
- R4: `adc_start` is a one-cycle pulse. It rises only after `sw_sel` has held the same non-zero value for SETTLE (default 3) sampled cycles.
- R5: The fine field `res_data[4:0]` equals the `adc_code` present in the cycle `adc_done` is high during conversion.
- R6: With no partial channel, the fine field is zero and no `adc_start` is issued. This includes the all-full case, where every channel is full and the result is coarse 15, fine 0.
- R7: `res_range_err` is 1 when some channel has its high bit set and its low bit clear, otherwise 0.
- R8: `res_bubble` is 1 when the high vector is not a run of ones starting at bit 0, otherwise 0.
- R9: A START during readout opens all switches within one cycle of the synchronized edge. The cancelled measurement produces no result.
- R10: `res_valid` stays high with stable data and flags until accepted with `res_ready`. A later result waits for the slot.
- R11: After reset, `sw_sel`, `adc_start` and `res_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_async | input | 1 | START event, asynchronous |
| stop_async | input | 1 | STOP event, asynchronous |
| hi_cmp | input | 15 | Per-channel above-high-threshold comparator results |
| lo_cmp | input | 15 | Per-channel above-low-threshold comparator results |
| sw_sel | output | 15 | One-hot switch select toward the fine ADC |
| adc_start | output | 1 | One-cycle ADC conversion request |
| adc_done | input | 1 | ADC conversion complete |
| adc_code | input | 5 | ADC output code |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted by the consumer |
| res_data | output | 9 | {coarse[3:0], fine[4:0]} |
| res_range_err | output | 1 | A channel is above the high threshold but below the low threshold |
| res_bubble | output | 1 | The full-channel pattern is not contiguous |

## Verification
A wrong phase state shows up as a missing or unexpected `adc_start`, or as a result that never appears. This is visible within a few cycles after the synchronized STOP falling edge. A wrong snapshot or decode shows up directly in the coarse field, in the one-hot `sw_sel` pattern, or in the flags of the next result. A wrong settle counter shows up as an `adc_start` that arrives after the wrong number of stable select cycles. A fault in the output register shows up as data changing while `res_ready` is held low.

// File: rtl/tdc_seq_pkg.sv
package tdc_seq_pkg;
  typedef enum logic [2:0] {
    PH_WAIT,
    PH_RESET,
    PH_CHARGE,
    PH_SELECT,
    PH_SETTLE,
    PH_CONVERT,
    PH_EMIT
  } phase_t;
endpackage

// File: rtl/tdc_sync_edge.sv
module tdc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/tdc_therm_decode.sv
module tdc_therm_decode #(
  parameter int NCH = 15,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic [NCH-1:0] hi_v,
  input  logic [NCH-1:0] lo_v,
  output logic [CW-1:0]  coarse,
  output logic [NCH-1:0] sel,
  output logic           partial,
  output logic           range_err,
  output logic           bubble
);
  always_comb begin
    coarse = '0;
    for (int i = 0; i < NCH; i++) coarse = coarse + CW'(hi_v[i]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign sel[g] = (coarse == CW'(g)) && lo_v[g] && !hi_v[g];
  end

  assign partial   = |sel;
  assign range_err = |(hi_v & ~lo_v);
  assign bubble    = |(hi_v & (hi_v + NCH'(1)));
endmodule

// File: rtl/tdc_out_reg.sv
module tdc_out_reg #(
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] din,
  input  logic          din_rerr,
  input  logic          din_bub,
  input  logic          ready,
  output logic          valid,
  output logic [RW-1:0] dout,
  output logic          dout_rerr,
  output logic          dout_bub,
  output logic          free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      dout      <= '0;
      dout_rerr <= 1'b0;
      dout_bub  <= 1'b0;
    end else if (load) begin
      valid     <= 1'b1;
      dout      <= din;
      dout_rerr <= din_rerr;
      dout_bub  <= din_bub;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tdc_readout_seq.sv
module tdc_readout_seq
  import tdc_seq_pkg::*;
#(
  parameter int NCH    = 15,
  parameter int FW     = 5,
  parameter int SETTLE = 3,
  localparam int CW = $clog2(NCH + 1),
  localparam int RW = CW + FW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_async,
  input  logic           stop_async,
  input  logic [NCH-1:0] hi_cmp,
  input  logic [NCH-1:0] lo_cmp,
  output logic [NCH-1:0] sw_sel,
  output logic           adc_start,
  input  logic           adc_done,
  input  logic [FW-1:0]  adc_code,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [RW-1:0]  res_data,
  output logic           res_range_err,
  output logic           res_bubble
);
  localparam int SCW = $clog2(SETTLE + 1);

  phase_t         phase;
  logic           start_rise, start_fall_unused;
  logic           stop_rise, stop_fall;
  logic [NCH-1:0] hi_q, lo_q, sel_w;
  logic [CW-1:0]  coarse_w;
  logic           partial_w, rerr_w, bub_w;
  logic [FW-1:0]  fine_q;
  logic [SCW-1:0] settle_cnt;
  logic           load, slot_free;

  tdc_sync_edge #(.STAGES(2)) u_sync_start (
    .clk(clk), .rst_n(rst_n), .din(start_async),
    .rise(start_rise), .fall(start_fall_unused)
  );

  tdc_sync_edge #(.STAGES(2)) u_sync_stop (
    .clk(clk), .rst_n(rst_n), .din(stop_async),
    .rise(stop_rise), .fall(stop_fall)
  );

  tdc_therm_decode #(.NCH(NCH)) u_dec (
    .hi_v(hi_q), .lo_v(lo_q), .coarse(coarse_w), .sel(sel_w),
    .partial(partial_w), .range_err(rerr_w), .bubble(bub_w)
  );

  assign load = (phase == PH_EMIT) && slot_free && !start_rise;

  tdc_out_reg #(.RW(RW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load),
    .din({coarse_w, fine_q}), .din_rerr(rerr_w), .din_bub(bub_w),
    .ready(res_ready), .valid(res_valid), .dout(res_data),
    .dout_rerr(res_range_err), .dout_bub(res_bubble), .free(slot_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_WAIT;
      hi_q       <= '0;
      lo_q       <= '0;
      sw_sel     <= '0;
      adc_start  <= 1'b0;
      fine_q     <= '0;
      settle_cnt <= '0;
    end else begin
      adc_start <= 1'b0;
      if (start_rise) begin
        phase  <= PH_RESET;
        sw_sel <= '0;
      end else begin
        case (phase)
          PH_RESET:  if (stop_rise) phase <= PH_CHARGE;
          PH_CHARGE: if (stop_fall) begin
            hi_q  <= hi_cmp;
            lo_q  <= lo_cmp;
            phase <= PH_SELECT;
          end
          PH_SELECT: if (partial_w) begin
            sw_sel     <= sel_w;
            settle_cnt <= '0;
            phase      <= PH_SETTLE;
          end else begin
            fine_q <= '0;
            phase  <= PH_EMIT;
          end
          PH_SETTLE: if (settle_cnt == SCW'(SETTLE - 1)) begin
            adc_start <= 1'b1;
            phase     <= PH_CONVERT;
          end else begin
            settle_cnt <= settle_cnt + SCW'(1);
          end
          PH_CONVERT: if (adc_done) begin
            fine_q <= adc_code;
            sw_sel <= '0;
            phase  <= PH_EMIT;
          end
          PH_EMIT: if (slot_free) phase <= PH_WAIT;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tdc_readout_seq_chk.sv
module tdc_readout_seq_chk #(
  parameter int NCH    = 15,
  parameter int FW     = 5,
  parameter int SETTLE = 3,
  localparam int CW = $clog2(NCH + 1),
  localparam int RW = CW + FW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_rise,
  input logic [NCH-1:0] sw_sel,
  input logic           adc_start,
  input logic           res_valid,
  input logic           res_ready,
  input logic [RW-1:0]  res_data,
  input logic           res_range_err,
  input logic           res_bubble
);
  logic [NCH-1:0] prev_sel;
  int unsigned    run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sel <= '0;
      run_cnt  <= 0;
    end else begin
      prev_sel <= sw_sel;
      if (sw_sel == '0)            run_cnt <= 0;
      else if (sw_sel != prev_sel) run_cnt <= 1;
      else if (run_cnt < 1000)     run_cnt <= run_cnt + 1;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_sel)); // R3
  AST_ADC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R4
  AST_ADC_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (sw_sel != '0 && run_cnt >= SETTLE)); // R4
  AST_FULL_NO_FINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(res_valid) && res_data[RW-1:FW] == CW'(NCH)) |-> res_data[FW-1:0] == '0); // R6
  AST_ABORT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> (sw_sel == '0 && !adc_start)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)
      && $stable(res_range_err) && $stable(res_bubble))); // R10
endmodule

bind tdc_readout_seq tdc_readout_seq_chk #(.NCH(NCH), .FW(FW), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .sw_sel(sw_sel),
  .adc_start(adc_start), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .res_range_err(res_range_err), .res_bubble(res_bubble)
);

// File: tb/tdc_readout_seq_test.sv
module tdc_readout_seq_test;
  localparam int NCH = 15;
  localparam int FW = 5;
  localparam int SETTLE = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_async = 1'b0, stop_async = 1'b0;
  logic [NCH-1:0] hi_cmp = '0, lo_cmp = '0;
  logic [NCH-1:0] sw_sel;
  logic           adc_start, adc_done = 1'b0;
  logic [FW-1:0]  adc_code = '0;
  logic           res_valid, res_ready = 1'b1;
  logic [8:0]     res_data;
  logic           res_range_err, res_bubble;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tdc_readout_seq #(.NCH(NCH), .FW(FW), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start_async(start_async), .stop_async(stop_async),
    .hi_cmp(hi_cmp), .lo_cmp(lo_cmp), .sw_sel(sw_sel), .adc_start(adc_start),
    .adc_done(adc_done), .adc_code(adc_code), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_range_err(res_range_err),
    .res_bubble(res_bubble)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_async = 1'b1;
    repeat (3) @(posedge clk);
    start_async = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  // One measurement; the bench plays the ADC. chk_out=0 leaves the output unchecked.
  task automatic run_meas(input logic [NCH-1:0] hv, input logic [NCH-1:0] lv,
                          input logic [FW-1:0] code, input bit exp_adc, input int exp_idx,
                          input logic [8:0] exp_data, input bit exp_rerr, input bit exp_bub,
                          input bit chk_out);
    int settle_n = 0;
    bit saw_adc = 0, got = 0;
    logic [NCH-1:0] sel_at = '0;
    pulse_start();
    stop_async = 1'b1;
    hi_cmp = hv;
    lo_cmp = lv;
    repeat (4) @(posedge clk);
    stop_async = 1'b0;
    for (int c = 0; c < 60 && !got; c++) begin
      @(negedge clk);
      if (adc_start && !saw_adc) begin
        saw_adc = 1;
        sel_at = sw_sel;
        @(negedge clk);
        chk(!adc_start, "R4", "adc_start width", adc_start, 0);
        adc_done = 1'b1;
        adc_code = code;
        @(negedge clk);
        adc_done = 1'b0;
        adc_code = '0;
      end else if (!saw_adc && sw_sel != '0) begin
        settle_n++;
      end
      if (chk_out && res_valid) got = 1;
    end
    chk(saw_adc == exp_adc, exp_adc ? "R4" : "R6", "adc started", saw_adc, exp_adc);
    if (exp_adc) begin
      chk(sel_at == (NCH'(1) << exp_idx), "R3", "switch select", sel_at, NCH'(1) << exp_idx);
      chk(settle_n == SETTLE, "R4", "settle cycles", settle_n, SETTLE);
    end
    if (chk_out) begin
      chk(got, "R10", "result appeared", got, 1);
      chk(res_data[8:5] == exp_data[8:5], "R2", "coarse field", res_data[8:5], exp_data[8:5]);
      chk(res_data[4:0] == exp_data[4:0], exp_adc ? "R5" : "R6", "fine field", res_data[4:0], exp_data[4:0]);
      chk(res_range_err == exp_rerr, "R7", "range flag", res_range_err, exp_rerr);
      chk(res_bubble == exp_bub, "R8", "bubble flag", res_bubble, exp_bub);
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] t;
    logic [15:0] u;
    logic [FW-1:0] code;
    bit seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(sw_sel == '0, "R11", "sw_sel at reset", sw_sel, 0);
    chk(!adc_start, "R11", "adc_start at reset", adc_start, 0);
    chk(!res_valid, "R11", "res_valid at reset", res_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2 R3 R5: sweep every coarse count with a partial channel
    for (int k = 0; k < NCH; k++) begin
      t = (16'd1 << k) - 16'd1;
      u = (16'd1 << (k + 1)) - 16'd1;
      code = FW'((k * 7 + 3) % 32);
      run_meas(t[NCH-1:0], u[NCH-1:0], code, 1, k, {4'(k), code}, 0, 0, 1);
    end
    // R6: no partial channel, including all full
    for (int k = 0; k <= NCH; k++) begin
      t = (16'd1 << k) - 16'd1;
      run_meas(t[NCH-1:0], t[NCH-1:0], 5'd9, 0, 0, {4'(k), 5'd0}, 0, 0, 1);
    end
    // R8: bubble, channels 0,1,3 full; count 3 lands on a full channel
    run_meas(15'b000_0000_0000_1011, 15'b000_0000_0001_1111, 5'd4, 0, 0, {4'd3, 5'd0}, 0, 1, 1);
    // R7: channel 1 high without low; partial at index 2
    run_meas(15'b000_0000_0000_0011, 15'b000_0000_0000_0101, 5'd17, 1, 2, {4'd2, 5'd17}, 1, 0, 1);

    // R1: STOP pulse while waiting does nothing
    seen = 0;
    stop_async = 1'b1;
    repeat (4) @(posedge clk);
    stop_async = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (adc_start || res_valid) seen = 1;
    end
    chk(!seen, "R1", "stop outside reset phase", seen, 0);

    // R9: abort during conversion
    pulse_start();
    hi_cmp = 15'h000F;
    lo_cmp = 15'h001F;
    stop_async = 1'b1;
    repeat (4) @(posedge clk);
    stop_async = 1'b0;
    seen = 0;
    for (int c = 0; c < 30 && !seen; c++) begin
      @(negedge clk);
      if (adc_start) seen = 1;
    end
    chk(seen, "R9", "readout reached conversion", seen, 1);
    start_async = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sw_sel == '0, "R9", "switches open after abort", sw_sel, 0);
    start_async = 1'b0;
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (res_valid) seen = 1;
    end
    chk(!seen, "R9", "no result from aborted run", seen, 0);
    run_meas(15'h0007, 15'h000F, 5'd21, 1, 3, {4'd3, 5'd21}, 0, 0, 1);

    // R10: back-pressure
    res_ready = 1'b0;
    run_meas(15'h0001, 15'h0003, 5'd11, 1, 1, {4'd1, 5'd11}, 0, 0, 1);
    run_meas(15'h003F, 15'h007F, 5'd30, 1, 6, {4'd6, 5'd30}, 0, 0, 0);
    chk(res_valid && res_data == {4'd1, 5'd11}, "R10", "first result held", res_data, {4'd1, 5'd11});
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid && res_data == {4'd6, 5'd30}, "R10", "second result after accept", res_data, {4'd6, 5'd30});
    @(negedge clk);
    chk(!res_valid, "R10", "valid cleared after accept", res_valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule